// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Mask

This block holds the static control settings of a storage-interface PHY. It has seven 32-bit control words and one read-only status word, reached over a plain single-cycle bus. The bus has an address, a write strobe, write data, a read strobe and read data. Each control write carries its own bit mask in the upper half of the data word. Only the low-half bits whose mask bit is set take the new value, so software can flip one field without reading the register first.

Several fields of the stored words leave the block as dedicated pins: analog power enable (active-high power-down-bar), delay-line enable, a 3-bit output impedance code, a 2-bit clock range code, an output tap delay enable and a 4-bit tap delay value. Two PHY inputs, calibration complete and delay-line locked, are visible in the status word. After reset every control bit is zero, so the PHY starts powered down with the delay line off.

Top module: `phy_ctrl_regs`

## Requirements
- R1: On a write to a control word, low bit x takes write-data bit x only when write-data bit x+16 is 1. Every other low bit keeps its value, and a write whose upper half is zero changes nothing.
- R2: The seven control words sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Each has its own storage.
- R3: Control word 6 (0x18) drives the power enable from bit 0 and the delay-line enable from bit 1. It drives the impedance code from bits 6:4, where 0=50, 1=33, 2=66, 3=100 and 4=40 ohm.
- R4: Control word 0 (0x00) drives the tap delay value from bits 10:7 and the tap enable from bit 11. It drives the clock range code from bits 13:12, where 0=200, 1=50, 2=100 and 3=150 MHz.
- R5: A read of 0x20 returns delay-line locked at bit 5 and calibration complete at bit 6. All other bits read zero.
- R6: A read of a control word returns its 16 stored bits in bits 15:0, with bits 31:16 zero.
- R7: Writes to 0x20 and to any unmapped address have no effect. Unmapped addresses are 0x1C, anything above 0x20, and any address whose two low bits are not zero. Reads of unmapped addresses return zero.
- R8: Reset clears every control bit, so every field output is zero.
- R9: Read data is registered. It shows the addressed value in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: mask in 31:16, value in 15:0 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | PHY calibration complete |
| dll_lock_i | input | 1 | PHY delay line locked |
| phy_pwr_on | output | 1 | Analog power enable (power-down-bar) |
| dll_en | output | 1 | Delay-line enable |
| drv_code | output | 3 | Output impedance code |
| freq_code | output | 2 | Clock range code |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay value |

## Verification
The bench targets partial-mask writes that change one field and leave its neighbours alone; a design that ignored the mask would clear those neighbours. It writes all-ones to the status word, to the hole at 0x1C, to addresses above the status word and to misaligned addresses. A decoder that ignored the low address bits or aliased the hole would then corrupt a control word or return non-zero data. It also reads back words written with mask bits set, to show that the mask half reads as zero. It drives each combination of the two status inputs, so swapped status bit positions are caught. It checks that read data holds across idle cycles, so a design that returns zero or keeps following the address when no read is requested is caught.

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs #(
  parameter int ADDR_W     = 6,
  parameter int NUM_CTRL   = 7,
  parameter int STATUS_OFS = 32,
  parameter int PWR_WORD   = 6,
  parameter int TAP_WORD   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              cal_done_i,
  input  logic              dll_lock_i,
  output logic              phy_pwr_on,
  output logic              dll_en,
  output logic [2:0]        drv_code,
  output logic [1:0]        freq_code,
  output logic              otap_en,
  output logic [3:0]        otap_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [15:0]      ctrl_q [NUM_CTRL];
  logic [IDX_W-1:0] word_idx;
  logic [NUM_CTRL-1:0] hit;
  logic             stat_sel;
  logic [31:0]      rd_next;
  logic [15:0]      wmask, wval;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign stat_sel = (bus_addr == STATUS_OFS[ADDR_W-1:0]);
  assign wmask    = bus_wdata[31:16];
  assign wval     = bus_wdata[15:0];

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_word
    assign hit[k] = (bus_addr[1:0] == 2'b00) && (word_idx == k[IDX_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl_q[k] <= '0;
      else if (bus_wr && hit[k])
        ctrl_q[k] <= (ctrl_q[k] & ~wmask) | (wval & wmask);
    end

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit[k]) |=> ((ctrl_q[k] & ~$past(wmask)) == ($past(ctrl_q[k]) & ~$past(wmask)))); // R1
    AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit[k]) |=> ((ctrl_q[k] & $past(wmask)) == ($past(wval) & $past(wmask)))); // R1
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit[k]) |=> $stable(ctrl_q[k])); // R7
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (hit[k]) rd_next = {16'b0, ctrl_q[k]};
    if (stat_sel) rd_next = {25'b0, cal_done_i, dll_lock_i, 5'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign phy_pwr_on = ctrl_q[PWR_WORD][0];
  assign dll_en     = ctrl_q[PWR_WORD][1];
  assign drv_code   = ctrl_q[PWR_WORD][6:4];
  assign otap_sel   = ctrl_q[TAP_WORD][10:7];
  assign otap_en    = ctrl_q[TAP_WORD][11];
  assign freq_code  = ctrl_q[TAP_WORD][13:12];

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (hit != '0)) |=> (bus_rdata[31:16] == 16'h0)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (hit == '0) && !stat_sel) |=> (bus_rdata == 32'h0)); // R7
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_sel) |=> (bus_rdata == {25'b0, $past(cal_done_i), $past(dll_lock_i), 5'b0})); // R5
endmodule

// File: tb/test_phy_ctrl_regs.sv
module test_phy_ctrl_regs;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        cal_done_i = 0, dll_lock_i = 0;
  logic        phy_pwr_on, dll_en, otap_en;
  logic [2:0]  drv_code;
  logic [1:0]  freq_code;
  logic [3:0]  otap_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  phy_ctrl_regs i_phy_ctrl_regs (.*);

  always #10 clk = ~clk;

  // behavioural reference model
  int unsigned mdl [7];
  logic [31:0] mdl_rd;

  function automatic bit mapped(input logic [5:0] a);
    return a[1:0] == 2'b00 && a < 6'h1C;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mdl[i]) mdl[i] = 0;
      mdl_rd = 0;
    end else begin
      if (bus_rd) begin
        if (mapped(bus_addr)) mdl_rd = mdl[bus_addr >> 2] & 32'hFFFF;
        else if (bus_addr == 6'h20) mdl_rd = (cal_done_i ? 32'h40 : 0) | (dll_lock_i ? 32'h20 : 0);
        else mdl_rd = 0;
      end
      if (bus_wr && mapped(bus_addr)) begin
        for (int b = 0; b < 16; b++)
          if (bus_wdata[b+16]) begin
            if (bus_wdata[b]) mdl[bus_addr >> 2] |= (1 << b);
            else mdl[bus_addr >> 2] &= ~(1 << b);
          end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 rdata vs model", bus_rdata, mdl_rd);
    chk("R3 power enable", 32'(phy_pwr_on), mdl[6] & 1);
    chk("R3 dll enable", 32'(dll_en), (mdl[6] >> 1) & 1);
    chk("R3 drive code", 32'(drv_code), (mdl[6] >> 4) & 7);
    chk("R4 tap value", 32'(otap_sel), (mdl[0] >> 7) & 15);
    chk("R4 tap enable", 32'(otap_en), (mdl[0] >> 11) & 1);
    chk("R4 freq code", 32'(freq_code), (mdl[0] >> 12) & 3);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic finish_up;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset outputs", {phy_pwr_on, dll_en, drv_code, freq_code, otap_en, otap_sel}, 0);
    rd(6'h18, v); chk("R8 reset word 6", v, 0);

    wr(6'h18, 32'h0073_0073);
    chk("R3 drive code 7", 32'(drv_code), 7);
    chk("R3 power on", 32'(phy_pwr_on), 1);
    wr(6'h18, 32'h0001_0000);
    rd(6'h18, v); chk("R1 single-bit clear keeps rest", v, 32'h72);
    wr(6'h18, 32'h0000_FFFF);
    rd(6'h18, v); chk("R1 zero mask no change", v, 32'h72);

    wr(6'h00, 32'h3F80_2A80);
    chk("R4 freq 100M code", 32'(freq_code), 2);
    chk("R4 tap value 5", 32'(otap_sel), 5);
    chk("R4 tap enable", 32'(otap_en), 1);

    for (int k = 1; k < 6; k++) wr(6'(4*k), 32'hFFFF_0000 | (32'h100 + k));
    for (int k = 1; k < 6; k++) begin
      rd(6'(4*k), v); chk("R2 word storage", v, 32'h100 + k);
    end

    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R6 upper half zero", v, 32'h0000_FFFF);

    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h02, 32'hFFFF_FFFF);
    wr(6'h19, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R7 misaligned write ignored", v, 32'h2A80);
    rd(6'h18, v); chk("R7 stray writes ignored", v, 32'h72);
    rd(6'h1C, v); chk("R7 hole reads zero", v, 0);
    rd(6'h21, v); chk("R7 misaligned read zero", v, 0);

    cal_done_i = 1; dll_lock_i = 0;
    rd(6'h20, v); chk("R5 cal done bit 6", v, 32'h40);
    dll_lock_i = 1;
    rd(6'h20, v); chk("R5 both bits", v, 32'h60);
    cal_done_i = 0;
    rd(6'h20, v); chk("R5 dll lock bit 5", v, 32'h20);
    dll_lock_i = 0;
    repeat (3) @(negedge clk);
    chk("R9 rdata held while idle", bus_rdata, 32'h20);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_addr   = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'(4 * $urandom_range(0, 8));
      bus_wdata  = $urandom;
      bus_wr     = $urandom_range(0, 1);
      bus_rd     = $urandom_range(0, 1);
      cal_done_i = $urandom_range(0, 1);
      dll_lock_i = $urandom_range(0, 1);
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule